// File: doc/BRIEF.md
# Variable Bit-Field Extract and Insert Unit

This unit performs field extraction and field insertion on a 64-bit datapath. A single instruction word tells it which of eight variants to run and where the field sits. One 5-bit field gives the lowest bit position. A second 5-bit field gives either the field length minus one (extracts) or the top bit position (inserts). Some variants add a bias of 32 to one or both of these values. This lets a 5-bit encoding reach every field of a 64-bit word.

The unit sits after operand fetch. Each operation presents the source operand and the current destination value. The destination value is needed because an insert keeps every bit outside the field. After one register stage the unit returns the result, a write-enable and a valid flag. The write-enable is dropped in two cases: an insert whose range is reversed, and an instruction word the unit does not recognise. In both cases the destination keeps its old value.

Top module: `bfx_unit`

## Requirements
- R1: The unit recognises an instruction only when bits [31:26] are 011111 and bits [5:3] are 000. For any other word it presents a result equal to `rt_i` with `wen_o` low.
- R2: Function code 000000 is the 32-bit extract. Bits [10:6] give the start position `p` and bits [15:11] give `n`. The result holds bits `p` to `p+n` of the low 32 bits of `rs_i`, placed at bit 0. Bits above bit 31 are dropped. The 32-bit value is then sign-extended from its bit 31.
- R3: Function code 000011 is the 64-bit extract. It returns `n+1` bits of `rs_i` starting at bit `p`, zero-extended. Positions above 63 read as zero.
- R4: Function code 000001 is the long extract. It returns `n+33` bits of `rs_i` starting at bit `p`, zero-extended. Positions above 63 read as zero.
- R5: Function code 000010 is the high extract. It returns `n+1` bits of `rs_i` starting at bit `p+32`, zero-extended. Positions above 63 read as zero.
- R6: Function code 000100 is the 32-bit insert. The low bits of `rs_i`, shifted left by `p`, replace bits `n` down to `p` of the low word of `rt_i`. The other low-word bits of `rt_i` are kept, and the 32-bit value is sign-extended to 64 bits.
- R7: Function code 000111 is the 64-bit insert. The low bits of `rs_i`, shifted left by `p`, replace bits `n` down to `p` of `rt_i`. All other bits of `rt_i` are kept.
- R8: Function code 000101 is the insert with raised top. It replaces bits `n+32` down to `p` of `rt_i`. Because `p` can never exceed `n+32`, this variant always writes.
- R9: Function code 000110 is the high insert. It replaces bits `n+32` down to `p+32` of `rt_i` with the low bits of `rs_i` shifted left by `p+32`.
- R10: For the 32-bit, 64-bit and high inserts, `p > n` is a reversed range. A reversed range gives `wen_o` low and a result equal to `rt_i`.
- R11: `valid_o`, `wen_o` and `result_o` appear on the clock edge after the one that samples `valid_i`. A cycle with `valid_i` low gives `valid_o`, `wen_o` and `result_o` all zero.
- R12: A synchronous active-high reset clears `valid_o`, `wen_o` and `result_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation present this cycle |
| instr_i | input | 32 | Instruction word: major code, field values, function code |
| rs_i | input | 64 | Source operand |
| rt_i | input | 64 | Current destination value |
| valid_o | output | 1 | Registered result is present |
| wen_o | output | 1 | Destination must be written with `result_o` |
| result_o | output | 64 | Registered field result |

## Verification
Every variant is swept over all 1024 combinations of the two 5-bit fields. Each combination is run with two operand pairs whose bit 31 differs, so sign extension and zero extension give different results. The sweeps reach ranges that run past bit 63 or bit 31, where dropping the excess differs from wrapping it. They also reach reversed insert ranges, and the raised-top insert, which never skips its write. Further patterns cover an unknown major code and an unused function code, which must pass `rt_i` through unwritten, and idle cycles with non-zero operands, which must produce zeros.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

    localparam logic [5:0] MAJOR_CODE = 6'b011111;

    typedef enum logic [5:0] {
        FN_EXT_W  = 6'b000000,
        FN_EXT_LG = 6'b000001,
        FN_EXT_HI = 6'b000010,
        FN_EXT_D  = 6'b000011,
        FN_INS_W  = 6'b000100,
        FN_INS_LG = 6'b000101,
        FN_INS_HI = 6'b000110,
        FN_INS_D  = 6'b000111
    } fn_e;

    typedef struct packed {
        logic known;   // recognised instruction word
        logic ins;     // insert (else extract)
        logic w32;     // 32-bit form, sign-extended result
        logic noop;    // reversed insert range
    } opkind_t;

endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
    import bfx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:0]                instr_i,
    output opkind_t                    kind_o,
    output logic [$clog2(XLEN):0]      lo_o,
    output logic [$clog2(XLEN):0]      hi_o
);
    localparam int POS_W = $clog2(XLEN) + 1;
    localparam int FLD_W = $clog2(XLEN / 2);
    localparam logic [POS_W-1:0] BIAS = POS_W'(XLEN / 2);

    logic [POS_W-1:0] top_f;
    logic [POS_W-1:0] low_f;
    logic             major_ok;
    fn_e              fn;

    assign top_f    = POS_W'(instr_i[6+FLD_W +: FLD_W]);
    assign low_f    = POS_W'(instr_i[6 +: FLD_W]);
    assign major_ok = (instr_i[31:26] == MAJOR_CODE) && (instr_i[5:3] == 3'b000);
    assign fn       = fn_e'(instr_i[5:0]);

    wire unused_regfields = ^instr_i[25:16];

    always_comb begin
        kind_o       = '0;
        kind_o.known = major_ok;
        lo_o         = low_f;
        hi_o         = top_f;
        unique case (fn)
            FN_EXT_W:  kind_o.w32 = 1'b1;
            FN_EXT_D:  ;
            FN_EXT_LG: hi_o = top_f + BIAS;
            FN_EXT_HI: lo_o = low_f + BIAS;
            FN_INS_W: begin
                kind_o.ins  = 1'b1;
                kind_o.w32  = 1'b1;
                kind_o.noop = low_f > top_f;
            end
            FN_INS_D: begin
                kind_o.ins  = 1'b1;
                kind_o.noop = low_f > top_f;
            end
            FN_INS_LG: begin
                kind_o.ins  = 1'b1;
                hi_o        = top_f + BIAS;
                kind_o.noop = low_f > (top_f + BIAS);
            end
            FN_INS_HI: begin
                kind_o.ins  = 1'b1;
                lo_o        = low_f + BIAS;
                hi_o        = top_f + BIAS;
                kind_o.noop = low_f > top_f;
            end
            default: kind_o.known = 1'b0;
        endcase
    end

endmodule

// File: rtl/bfx_span_mask.sv
module bfx_span_mask #(
    parameter int XLEN = 64
) (
    input  logic [$clog2(XLEN):0] lo_i,
    input  logic [$clog2(XLEN):0] hi_i,
    output logic [XLEN-1:0]       mask_o
);
    localparam int POS_W = $clog2(XLEN) + 1;

    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        localparam logic [POS_W-1:0] IDX = POS_W'(i);
        assign mask_o[i] = (IDX >= lo_i) && (IDX <= hi_i);
    end

endmodule

// File: rtl/bfx_field_alu.sv
module bfx_field_alu
    import bfx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  opkind_t               kind_i,
    input  logic [$clog2(XLEN):0] lo_i,
    input  logic [$clog2(XLEN):0] hi_i,
    input  logic [XLEN-1:0]       rs_i,
    input  logic [XLEN-1:0]       rt_i,
    output logic [XLEN-1:0]       res_o
);
    localparam int POS_W = $clog2(XLEN) + 1;
    localparam int HALF  = XLEN / 2;

    logic [XLEN-1:0] span_m;
    logic [XLEN-1:0] keep_m;
    logic [XLEN-1:0] ext_src;
    logic [XLEN-1:0] ext_raw;
    logic [XLEN-1:0] ins_raw;
    logic [XLEN-1:0] picked;

    bfx_span_mask #(.XLEN(XLEN)) u_span (
        .lo_i   (lo_i),
        .hi_i   (hi_i),
        .mask_o (span_m)
    );

    bfx_span_mask #(.XLEN(XLEN)) u_keep (
        .lo_i   ('0),
        .hi_i   (hi_i),
        .mask_o (keep_m)
    );

    always_comb begin
        ext_src = kind_i.w32 ? {{HALF{1'b0}}, rs_i[HALF-1:0]} : rs_i;
        ext_raw = (ext_src >> lo_i) & keep_m;
        ins_raw = (rt_i & ~span_m) | ((rs_i << lo_i) & span_m);
        picked  = kind_i.ins ? ins_raw : ext_raw;
        if (!kind_i.known || kind_i.noop) begin
            res_o = rt_i;
        end else if (kind_i.w32) begin
            res_o = {{HALF{picked[HALF-1]}}, picked[HALF-1:0]};
        end else begin
            res_o = picked;
        end
    end

endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
    import bfx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            valid_i,
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] rs_i,
    input  logic [XLEN-1:0] rt_i,
    output logic            valid_o,
    output logic            wen_o,
    output logic [XLEN-1:0] result_o
);
    localparam int POS_W = $clog2(XLEN) + 1;
    localparam int HALF  = XLEN / 2;

    typedef struct packed {
        logic            valid;
        logic            wen;
        logic [XLEN-1:0] result;
    } stage_t;

    opkind_t          kind;
    logic [POS_W-1:0] lo_pos;
    logic [POS_W-1:0] hi_pos;
    logic [XLEN-1:0]  alu_res;
    stage_t           stage_d, stage_q;
    logic             armed_d, armed_q;

    bfx_decode #(.XLEN(XLEN)) u_dec (
        .instr_i (instr_i),
        .kind_o  (kind),
        .lo_o    (lo_pos),
        .hi_o    (hi_pos)
    );

    bfx_field_alu #(.XLEN(XLEN)) u_alu (
        .kind_i (kind),
        .lo_i   (lo_pos),
        .hi_i   (hi_pos),
        .rs_i   (rs_i),
        .rt_i   (rt_i),
        .res_o  (alu_res)
    );

    always_comb begin
        stage_d        = '0;
        stage_d.valid  = valid_i;
        stage_d.wen    = valid_i && kind.known && !kind.noop;
        stage_d.result = valid_i ? alu_res : '0;
        armed_d        = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage_q <= '0;
            armed_q <= 1'b0;
        end else begin
            stage_q <= stage_d;
            armed_q <= armed_d;
        end
    end

    assign valid_o  = stage_q.valid;
    assign wen_o    = stage_q.wen;
    assign result_o = stage_q.result;

    // R11: outputs follow the strobe by exactly one edge
    p_valid_lat_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        armed_q |-> (valid_o == $past(valid_i)));

    // R11: an idle cycle carries no write and no data
    p_idle_zero_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && !valid_o) |-> (!wen_o && result_o == '0));

    // R10 and R1: a skipped write hands back the old destination
    p_hold_dest_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && valid_o && !wen_o) |-> (result_o == $past(rt_i)));

    // R1: a foreign major code never writes
    p_foreign_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && $past(instr_i[31:26] != MAJOR_CODE)) |-> !wen_o);

    // R2 and R6: 32-bit forms return a sign-extended word
    p_sext_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && wen_o && ($past(instr_i[5:0]) == FN_EXT_W || $past(instr_i[5:0]) == FN_INS_W))
        |-> (result_o[XLEN-1:HALF] == {HALF{result_o[HALF-1]}}));

    // R3: the 64-bit extract leaves nothing above the field length
    p_zext_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && wen_o && $past(instr_i[5:0]) == FN_EXT_D)
        |-> ((result_o >> (POS_W'($past(instr_i[15:11])) + POS_W'(1))) == '0));

    // R8: the raised-top insert always writes
    p_raised_writes_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && valid_o && $past(instr_i[31:26] == MAJOR_CODE && instr_i[5:0] == FN_INS_LG))
        |-> wen_o);

endmodule

// File: tb/bfx_unit_test.sv
module bfx_unit_test;

    logic        clk = 1'b0;
    logic        rst_i;
    logic        valid_i;
    logic [31:0] instr_i;
    logic [63:0] rs_i;
    logic [63:0] rt_i;
    logic        valid_o;
    logic        wen_o;
    logic [63:0] result_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    bfx_unit uut (
        .clk_i    (clk),
        .rst_i    (rst_i),
        .valid_i  (valid_i),
        .instr_i  (instr_i),
        .rs_i     (rs_i),
        .rt_i     (rt_i),
        .valid_o  (valid_o),
        .wen_o    (wen_o),
        .result_o (result_o)
    );

    function automatic logic [63:0] ones(int n);
        if (n <= 0) return 64'd0;
        if (n >= 64) return '1;
        return (64'd1 << n) - 64'd1;
    endfunction

    function automatic logic [63:0] sx32(logic [63:0] v);
        return {{32{v[31]}}, v[31:0]};
    endfunction

    // returns {wen, result}
    function automatic logic [64:0] model(int fn, int a, int b, logic [63:0] rs, logic [63:0] rt);
        logic [63:0] m, r;
        int lo, hi;
        case (fn)
            0: return {1'b1, sx32((({32'd0, rs[31:0]}) >> b) & ones(a + 1))};
            3: return {1'b1, (rs >> b) & ones(a + 1)};
            1: return {1'b1, (rs >> b) & ones(a + 33)};
            2: return {1'b1, (rs >> (b + 32)) & ones(a + 1)};
            default: begin
                lo = b; hi = a;
                if (fn == 5) hi = a + 32;
                if (fn == 6) begin lo = b + 32; hi = a + 32; end
                if (lo > hi) return {1'b0, rt};
                m = ones(hi + 1) & ~ones(lo);
                r = (rt & ~m) | ((rs << lo) & m);
                if (fn == 4) r = sx32(r);
                return {1'b1, r};
            end
        endcase
    endfunction

    function automatic string tag_of(int fn, bit wexp);
        if (!wexp) return "R10";
        case (fn)
            0: return "R2";
            3: return "R3";
            1: return "R4";
            2: return "R5";
            4: return "R6";
            7: return "R7";
            5: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, bit ev, bit ew, logic [63:0] er);
        total++;
        if (valid_o !== ev || wen_o !== ew || result_o !== er) begin
            bad++;
            $display("FAIL %s: got v=%b w=%b r=%h expected v=%b w=%b r=%h",
                     tag, valid_o, wen_o, result_o, ev, ew, er);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic run(bit v, logic [31:0] ins, logic [63:0] rs, logic [63:0] rt);
        valid_i = v; instr_i = ins; rs_i = rs; rt_i = rt;
        @(negedge clk);
    endtask

    initial begin
        rst_i = 1'b1; valid_i = 1'b0; instr_i = '0; rs_i = '0; rt_i = '0;
        @(negedge clk); @(negedge clk);
        check("R12", 1'b0, 1'b0, 64'd0);
        rst_i = 1'b0;

        // R11: idle cycle with busy operands
        run(1'b0, {6'b011111, 10'd0, 5'd31, 5'd0, 6'b000011}, '1, '1);
        check("R11", 1'b0, 1'b0, 64'd0);

        // R1: foreign major code, then unused function code
        run(1'b1, {6'b000000, 10'd0, 5'd7, 5'd3, 6'b000000}, 64'h1111, 64'hCAFE_F00D_1234_5678);
        check("R1", 1'b1, 1'b0, 64'hCAFE_F00D_1234_5678);
        run(1'b1, {6'b011111, 10'd0, 5'd7, 5'd3, 6'b001000}, 64'h2222, 64'h0BAD_BEEF_0000_0001);
        check("R1", 1'b1, 1'b0, 64'h0BAD_BEEF_0000_0001);

        // R2..R10: every variant, every field pair, two operand sets
        for (int fn = 0; fn < 8; fn++) begin
            for (int a = 0; a < 32; a++) begin
                for (int b = 0; b < 32; b++) begin
                    for (int k = 0; k < 2; k++) begin
                        logic [63:0] rs, rt;
                        logic [64:0] e;
                        rs = (k == 0) ? 64'hA5C3_96F0_1E2D_7B48 : ~64'hA5C3_96F0_1E2D_7B48;
                        rt = (k == 0) ? 64'h0123_4567_89AB_CDEF : 64'hF0E1_D2C3_B4A5_9687;
                        e  = model(fn, a, b, rs, rt);
                        run(1'b1, {6'b011111, 10'd0, 5'(a), 5'(b), 6'(fn)}, rs, rt);
                        check(tag_of(fn, e[64]), 1'b1, e[64], e[63:0]);
                    end
                end
            end
        end

        // R11: back to idle after a burst
        run(1'b0, '0, '1, '1);
        check("R11", 1'b0, 1'b0, 64'd0);

        // R12: reset mid-stream clears outputs
        run(1'b1, {6'b011111, 10'd0, 5'd31, 5'd0, 6'b000011}, '1, '1);
        rst_i = 1'b1;
        @(negedge clk);
        check("R12", 1'b0, 1'b0, 64'd0);
        rst_i = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule